// File: doc/BRIEF.md
# Programmable FIFO Flag Offset Registers

This block keeps the two threshold offsets that a FIFO's flag logic compares against its fill level: one for the almost-empty flag and one for the almost-full flag. Both values are always present on dedicated outputs. Software or a board controller can change them in three ways: shift them in one bit at a time, write them as whole words from the write-side data bus, or read them back onto the read-side output register.

All three paths share a single two-state sequence pointer. The pointer names the almost-empty offset first and then the almost-full offset. It toggles after every completed load or readback. It returns to the almost-empty offset whenever the load select drops. The offset width follows the configured depth, and it grows by one bit when both ports run in the narrow (9-bit) bus mode. Readbacks must be separated by at least one idle read cycle. A readback attempted too early is refused and flagged. When the load select is low, the output register carries ordinary FIFO read data.

Top module: `flag_offset_regs`

## Requirements
- R1: After synchronous reset, `emptyOfs` and `fullOfs` both equal DEF_OFS (127 by default), `dataOut` is 0 and `protoErr` is 0.
- R2: While `loadSel` and `serEn` are high and `wrEn` and `rdEn` are low, one bit of `serData` is taken per clock, least significant bit first. After X bits, the assembled value is written to the offset named by the pointer (almost-empty first), and the pointer toggles. The next X bits then fill the almost-full offset, and later words keep alternating.
- R3: The offset width X is ADDR_BITS (11 by default) when `narrowMode` is 0, and ADDR_BITS+1 (12 by default) when `narrowMode` is 1. Offsets are ADDR_BITS+1 bits wide.
- R4: A clock with `loadSel` and `wrEn` high stores `dataIn[X-1:0]` into the offset named by the pointer and toggles the pointer. Bits of `dataIn` above X are ignored. The third and fourth words overwrite the almost-empty and almost-full offsets again.
- R5: A clock with `loadSel` and `rdEn` high and `wrEn` low is an accepted readback if the previous clock was not an accepted readback. One clock later, `dataOut` holds the offset named by the pointer, zero-extended, and the pointer toggles. Readbacks run in the order almost-empty, almost-full, almost-empty.
- R6: A readback attempted on the clock right after an accepted readback is refused. `dataOut` and the pointer keep their values, and `protoErr` is 1 for exactly the following clock. The attempt after a refused one is accepted.
- R7: A clock with `loadSel` low returns the pointer to the almost-empty offset and discards any partially shifted serial bits. While `loadSel` stays low, the offsets do not change.
- R8: With `loadSel` low, `rdEn` high loads `fifoData` into `dataOut` one clock later. A clock with `rdEn` low leaves `dataOut` unchanged.
- R9: With `loadSel` high, a parallel write takes priority over a readback, and a readback takes priority over a serial bit. The losing request has no effect that clock. A parallel write or a readback attempt also discards partial serial bits.
- R10: The pointer is shared across all paths, so a serial load of the almost-empty offset followed by a parallel write stores that write into the almost-full offset. At most one offset changes per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all paths |
| rst | input | 1 | Synchronous active-high reset |
| narrowMode | input | 1 | 1 when both ports use the 9-bit bus; widens offsets by one bit |
| loadSel | input | 1 | Routes writes, reads and serial bits to the offset registers |
| wrEn | input | 1 | Write-side enable; with loadSel, parallel offset load |
| dataIn | input | DATA_W | Write-side data bus |
| rdEn | input | 1 | Read-side enable; FIFO read or offset readback |
| fifoData | input | DATA_W | Normal FIFO read word from the memory path |
| dataOut | output | DATA_W | Read-side output register |
| serEn | input | 1 | Serial shift enable |
| serData | input | 1 | Serial data bit |
| emptyOfs | output | ADDR_BITS+1 | Current almost-empty offset |
| fullOfs | output | ADDR_BITS+1 | Current almost-full offset |
| protoErr | output | 1 | One-clock pulse: a readback came too soon and was refused |

## Verification
The assertions check, on every clock, the properties that need no knowledge of the pointer. A refusal pulse never lasts two clocks and always follows a readback attempt. Offsets stay frozen after a clock without load select. At most one offset moves per clock. The output register moves only after a read enable. Offsets written in wide mode never set the top bit. Only the bench's reference model can show the properties that depend on the pointer's history: serial bit order, which offset a given word lands in, wrap-around, the readback order, and the priority among simultaneous requests.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;

  // Strobes from the sequencing control to the offset datapath.
  typedef struct packed {
    logic shiftEn;     // take serData into the shift register
    logic shiftClr;    // discard partial serial bits
    logic ldEmpty;     // write the almost-empty offset
    logic ldFull;      // write the almost-full offset
    logic ldSerial;    // source of the write: 1 = serial word, 0 = dataIn
    logic outOfs;      // load an offset into the output register
    logic outSelFull;  // which offset goes out: 1 = almost-full
    logic outFifo;     // load fifoData into the output register
  } ofsStrobe_t;

endpackage

// File: rtl/flag_ofs_ctrl.sv
module flag_ofs_ctrl
  import flag_ofs_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       narrowMode,
  input  logic       loadSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       serEn,
  output ofsStrobe_t strobe,
  output logic       protoErr
);

  localparam int CNT_W = $clog2(OFS_W + 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(OFS_W - 1);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(OFS_W - 2);

  logic             seqFull;   // pointer: 0 = almost-empty, 1 = almost-full
  logic             lastRead;  // previous clock was an accepted readback
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastBit;

  logic doWrite, readTry, doRead, readErr, doSerial, serialDone, advance;

  assign lastBit    = narrowMode ? LAST_NARROW : LAST_WIDE;

  // Request decode with fixed priority: write, then readback, then serial bit.
  assign doWrite    = loadSel & wrEn;
  assign readTry    = loadSel & ~wrEn & rdEn;
  assign doRead     = readTry & ~lastRead;
  assign readErr    = readTry & lastRead;
  assign doSerial   = loadSel & ~wrEn & ~rdEn & serEn;
  assign serialDone = doSerial & (bitCnt == lastBit);
  assign advance    = doWrite | doRead | serialDone;

  always_comb begin
    strobe            = '0;
    strobe.shiftEn    = doSerial & ~serialDone;
    strobe.shiftClr   = ~loadSel | doWrite | readTry | serialDone;
    strobe.ldEmpty    = (doWrite | serialDone) & ~seqFull;
    strobe.ldFull     = (doWrite | serialDone) & seqFull;
    strobe.ldSerial   = serialDone;
    strobe.outOfs     = doRead;
    strobe.outSelFull = seqFull;
    strobe.outFifo    = ~loadSel & rdEn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seqFull  <= 1'b0;
      lastRead <= 1'b0;
      protoErr <= 1'b0;
      bitCnt   <= '0;
    end else begin
      lastRead <= doRead;
      protoErr <= readErr;
      if (!loadSel)     seqFull <= 1'b0;
      else if (advance) seqFull <= ~seqFull;
      if (strobe.shiftClr)     bitCnt <= '0;
      else if (strobe.shiftEn) bitCnt <= bitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/flag_ofs_datapath.sv
module flag_ofs_datapath
  import flag_ofs_pkg::*;
#(
  parameter int OFS_W   = 12,
  parameter int DATA_W  = 18,
  parameter int DEF_OFS = 127
) (
  input  logic              clk,
  input  logic              rst,
  input  ofsStrobe_t        strobe,
  input  logic              narrowMode,
  input  logic              serData,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] fifoData,
  output logic [OFS_W-1:0]  emptyOfs,
  output logic [OFS_W-1:0]  fullOfs,
  output logic [DATA_W-1:0] dataOut
);

  localparam logic [OFS_W-1:0] RESET_OFS = OFS_W'(DEF_OFS);
  localparam logic [OFS_W-1:0] WIDE_MASK = {1'b0, {(OFS_W-1){1'b1}}};
  localparam int PAD_W = DATA_W - OFS_W;

  logic [OFS_W-1:0]  shReg;
  logic [OFS_W-1:0]  shNext;
  logic [OFS_W-1:0]  serialWord;
  logic [OFS_W-1:0]  parWord;
  logic [OFS_W-1:0]  newOfs;
  logic [OFS_W-1:0]  readSel;
  logic [DATA_W-1:0] readWord;

  // LSB-first: each new bit enters at the top; a short word sits one place high.
  assign shNext     = {serData, shReg[OFS_W-1:1]};
  assign serialWord = narrowMode ? shNext : (shNext >> 1);
  assign parWord    = narrowMode ? dataIn[OFS_W-1:0] : (dataIn[OFS_W-1:0] & WIDE_MASK);
  assign newOfs     = strobe.ldSerial ? serialWord : parWord;
  assign readSel    = strobe.outSelFull ? fullOfs : emptyOfs;

  generate
    if (PAD_W > 0) begin : g_pad
      assign readWord = {{PAD_W{1'b0}}, readSel};
    end else begin : g_nopad
      assign readWord = readSel[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg    <= '0;
      emptyOfs <= RESET_OFS;
      fullOfs  <= RESET_OFS;
      dataOut  <= '0;
    end else begin
      if (strobe.shiftClr)     shReg <= '0;
      else if (strobe.shiftEn) shReg <= shNext;
      if (strobe.ldEmpty) emptyOfs <= newOfs;
      if (strobe.ldFull)  fullOfs  <= newOfs;
      if (strobe.outOfs)       dataOut <= readWord;
      else if (strobe.outFifo) dataOut <= fifoData;
    end
  end

endmodule

// File: rtl/flag_offset_regs.sv
module flag_offset_regs
  import flag_ofs_pkg::*;
#(
  parameter int ADDR_BITS = 11,
  parameter int DATA_W    = 18,
  parameter int DEF_OFS   = 127
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 narrowMode,
  input  logic                 loadSel,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    dataIn,
  input  logic                 rdEn,
  input  logic [DATA_W-1:0]    fifoData,
  output logic [DATA_W-1:0]    dataOut,
  input  logic                 serEn,
  input  logic                 serData,
  output logic [ADDR_BITS:0]   emptyOfs,
  output logic [ADDR_BITS:0]   fullOfs,
  output logic                 protoErr
);

  localparam int OFS_W = ADDR_BITS + 1;

  ofsStrobe_t strobe;

  flag_ofs_ctrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .narrowMode (narrowMode),
    .loadSel    (loadSel),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .serEn      (serEn),
    .strobe     (strobe),
    .protoErr   (protoErr)
  );

  flag_ofs_datapath #(.OFS_W(OFS_W), .DATA_W(DATA_W), .DEF_OFS(DEF_OFS)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .narrowMode (narrowMode),
    .serData    (serData),
    .dataIn     (dataIn),
    .fifoData   (fifoData),
    .emptyOfs   (emptyOfs),
    .fullOfs    (fullOfs),
    .dataOut    (dataOut)
  );

endmodule

// File: rtl/flag_offset_regs_chk.sv
module flag_offset_regs_chk #(
  parameter int OFS_W  = 12,
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              narrowMode,
  input logic              loadSel,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] dataOut,
  input logic [OFS_W-1:0]  emptyOfs,
  input logic [OFS_W-1:0]  fullOfs,
  input logic              protoErr
);

  // R6: a refusal lasts one clock and follows a readback attempt
  assert_err_single_R6: assert property (@(posedge clk) disable iff (rst)
    protoErr |=> !protoErr);
  assert_err_cause_R6: assert property (@(posedge clk) disable iff (rst)
    protoErr |-> $past(loadSel && rdEn && !wrEn));

  // R7: no load select, no offset change
  assert_ofs_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(loadSel) |-> ($stable(emptyOfs) && $stable(fullOfs)));

  // R10: at most one offset moves per clock
  assert_one_ofs_R10: assert property (@(posedge clk) disable iff (rst)
    !(!$stable(emptyOfs) && !$stable(fullOfs)));

  // R8: output register moves only after a read enable
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rdEn) |-> $stable(dataOut));

  // R4: a wide-mode parallel write never sets the top offset bit
  assert_wide_mask_R4: assert property (@(posedge clk) disable iff (rst)
    $past(loadSel && wrEn && !narrowMode) |->
      (($stable(emptyOfs) || !emptyOfs[OFS_W-1]) && ($stable(fullOfs) || !fullOfs[OFS_W-1])));

endmodule

bind flag_offset_regs flag_offset_regs_chk #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .narrowMode (narrowMode),
  .loadSel    (loadSel),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .dataOut    (dataOut),
  .emptyOfs   (emptyOfs),
  .fullOfs    (fullOfs),
  .protoErr   (protoErr)
);

// File: tb/test_flag_offset_regs.sv
`timescale 1ns/1ps
module test_flag_offset_regs;

  localparam int AB = 11;
  localparam int DW = 18;
  localparam int OW = AB + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic narrowMode = 1'b0;
  logic loadSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0, serEn = 1'b0, serData = 1'b0;
  logic [DW-1:0] dataIn = '0, fifoData = '0;
  logic [DW-1:0] dataOut;
  logic [OW-1:0] emptyOfs, fullOfs;
  logic protoErr;

  int checks = 0;
  int errors = 0;
  string curTag = "R1";

  always #2 clk = ~clk;

  flag_offset_regs #(.ADDR_BITS(AB), .DATA_W(DW), .DEF_OFS(127)) i_flag_offset_regs (
    .clk(clk), .rst(rst), .narrowMode(narrowMode), .loadSel(loadSel), .wrEn(wrEn),
    .dataIn(dataIn), .rdEn(rdEn), .fifoData(fifoData), .dataOut(dataOut),
    .serEn(serEn), .serData(serData), .emptyOfs(emptyOfs), .fullOfs(fullOfs),
    .protoErr(protoErr)
  );

  // Behavioural reference model
  int mEmpty = 127, mFull = 127, mPtr = 0, mBits = 0, mAcc = 0, mOut = 0;
  bit mLastRd = 0, mErr = 0;

  always @(posedge clk) begin
    int x, mask, w;
    x = narrowMode ? AB + 1 : AB;
    mask = (1 << x) - 1;
    if (rst) begin
      mEmpty = 127; mFull = 127; mPtr = 0; mBits = 0; mAcc = 0;
      mOut = 0; mLastRd = 0; mErr = 0;
    end else begin
      mErr = 0;
      if (!loadSel) begin
        mPtr = 0; mBits = 0; mAcc = 0; mLastRd = 0;
        if (rdEn) mOut = int'(fifoData);
      end else if (wrEn) begin
        w = int'(dataIn) & mask;
        if (mPtr == 0) mEmpty = w; else mFull = w;
        mPtr ^= 1; mBits = 0; mAcc = 0; mLastRd = 0;
      end else if (rdEn) begin
        mBits = 0; mAcc = 0;
        if (mLastRd) begin
          mErr = 1; mLastRd = 0;
        end else begin
          mOut = (mPtr == 0) ? mEmpty : mFull;
          mPtr ^= 1; mLastRd = 1;
        end
      end else begin
        mLastRd = 0;
        if (serEn) begin
          mAcc |= int'(serData) << mBits;
          mBits++;
          if (mBits == x) begin
            if (mPtr == 0) mEmpty = mAcc; else mFull = mAcc;
            mPtr ^= 1; mBits = 0; mAcc = 0;
          end
        end
      end
    end
  end

  // Compare with the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (int'(emptyOfs) != mEmpty || int'(fullOfs) != mFull ||
          int'(dataOut) != mOut || protoErr != mErr) begin
        errors++;
        $display("FAIL %s model: empty=%0h full=%0h out=%0h err=%0b expected empty=%0h full=%0h out=%0h err=%0b",
                 curTag, emptyOfs, fullOfs, dataOut, protoErr, mEmpty, mFull, mOut, mErr);
      end
    end
  end

  task automatic chk(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  // Drive one clock of inputs; returns at the next falling edge with outputs settled
  task automatic cyc(input bit ld, input bit wr, input bit rd, input bit se, input bit sd,
                     input logic [DW-1:0] din, input logic [DW-1:0] fd);
    loadSel = ld; wrEn = wr; rdEn = rd; serEn = se; serData = sd;
    dataIn = din; fifoData = fd;
    @(negedge clk);
  endtask

  task automatic serLoad(input int val, input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 1, val[i], '0, '0);
  endtask

  task automatic drop();
    cyc(0, 0, 0, 0, 0, '0, '0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    drop();
    curTag = "R1";
    chk("R1 emptyOfs", int'(emptyOfs), 127);
    chk("R1 fullOfs", int'(fullOfs), 127);
    chk("R1 dataOut", int'(dataOut), 0);
    chk("R1 protoErr", int'(protoErr), 0);

    curTag = "R2";
    serLoad('h2A5, 11);
    chk("R2 serial empty", int'(emptyOfs), 'h2A5);
    chk("R2 full untouched", int'(fullOfs), 127);
    serLoad('h15B, 11);
    chk("R2 serial full", int'(fullOfs), 'h15B);
    drop();

    curTag = "R3";
    narrowMode = 1'b1;
    serLoad('hABC, 12);
    chk("R3 narrow empty", int'(emptyOfs), 'hABC);
    serLoad('h923, 12);
    chk("R3 narrow full", int'(fullOfs), 'h923);
    drop();
    narrowMode = 1'b0;

    curTag = "R4";
    cyc(1, 1, 0, 0, 0, 18'h3F123, '0);
    chk("R4 par empty masked", int'(emptyOfs), 'h123);
    cyc(1, 1, 0, 0, 0, 18'h20FFF, '0);
    chk("R4 par full masked", int'(fullOfs), 'h7FF);
    cyc(1, 1, 0, 0, 0, 18'h00055, '0);
    chk("R4 wrap empty", int'(emptyOfs), 'h055);
    cyc(1, 1, 0, 0, 0, 18'h00066, '0);
    chk("R4 wrap full", int'(fullOfs), 'h066);
    drop();

    curTag = "R10";
    serLoad('h300, 11);
    cyc(1, 1, 0, 0, 0, 18'h00044, '0);
    chk("R10 serial then par empty", int'(emptyOfs), 'h300);
    chk("R10 par lands in full", int'(fullOfs), 'h044);
    drop();

    curTag = "R5";
    cyc(1, 0, 1, 0, 0, '0, 18'h3FFFF);
    chk("R5 read empty", int'(dataOut), 'h300);
    cyc(1, 0, 0, 0, 0, '0, '0);
    cyc(1, 0, 1, 0, 0, '0, '0);
    chk("R5 read full", int'(dataOut), 'h044);
    cyc(1, 0, 0, 0, 0, '0, '0);
    cyc(1, 0, 1, 0, 0, '0, '0);
    chk("R5 read empty again", int'(dataOut), 'h300);
    drop();

    curTag = "R6";
    cyc(1, 0, 1, 0, 0, '0, '0);
    chk("R6 first read", int'(dataOut), 'h300);
    cyc(1, 0, 1, 0, 0, '0, '0);
    chk("R6 error flagged", int'(protoErr), 1);
    chk("R6 output held", int'(dataOut), 'h300);
    cyc(1, 0, 1, 0, 0, '0, '0);
    chk("R6 retry accepted full", int'(dataOut), 'h044);
    chk("R6 error cleared", int'(protoErr), 0);
    drop();

    curTag = "R7";
    serLoad('h01F, 5);
    drop();
    chk("R7 offsets held", int'(emptyOfs), 'h300);
    serLoad('h011, 11);
    chk("R7 restart at empty", int'(emptyOfs), 'h011);
    chk("R7 full untouched", int'(fullOfs), 'h044);
    drop();
    cyc(1, 0, 1, 0, 0, '0, '0);
    chk("R7 read starts at empty", int'(dataOut), 'h011);
    drop();

    curTag = "R8";
    cyc(0, 0, 1, 0, 0, '0, 18'h2BEEF);
    chk("R8 fifo data out", int'(dataOut), 'h2BEEF);
    cyc(0, 0, 0, 0, 0, '0, 18'h11111);
    chk("R8 output holds", int'(dataOut), 'h2BEEF);

    curTag = "R9";
    cyc(1, 1, 1, 1, 1, 18'h000AA, 18'h12345);
    chk("R9 write wins", int'(emptyOfs), 'h0AA);
    chk("R9 no readback", int'(dataOut), 'h2BEEF);
    cyc(1, 0, 1, 1, 1, '0, '0);
    chk("R9 read beats serial", int'(dataOut), 'h044);
    drop();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule